// File: doc/BRIEF.md
# Byte-Enable SPI Register Access Master

This block lets a local host read and write the registers of an SPI-attached switch device whose register port selects bytes with a lane mask instead of taking a plain byte address that increments by itself. The host presents one request: a byte address, an access size of 1, 2 or 4 bytes, a read/write flag and write data. The block turns the request into a 16-bit command word and shifts that word out on the serial link. It then shifts out the write data, or captures the read data. Read data comes back right-aligned and zero-extended to 32 bits.

The command holds the word address (the byte address with its two low bits dropped), a 4-bit lane mask picked from the access size and the low address bits, and a write flag. The whole value is moved up two bit positions to leave a turnaround pad. The command goes out most significant byte first. Register data travels least significant byte first in both directions, and every byte is sent MSB first. The serial clock comes from the system clock through a fixed divider. The link runs in SPI mode 0, and chip select stays low for the whole transaction.

Top module: `spi_be_regmaster`

## Requirements
- R1: The 16-bit command carries address bits 10:2 in command bits 14:6 and the lane mask in bits 5:2, with bits 1:0 always zero.
- R2: For a 1-byte access (req_size = 1) the lane mask has exactly one bit set, at position req_addr[1:0].
- R3: For a 2-byte access (req_size = 2) the lane mask is 4'b1100 when req_addr[1] is 1 and 4'b0011 when it is 0.
- R4: For a 4-byte access (req_size = 4) the lane mask is 4'b1111.
- R5: Command bit 15 is 1 for a write (req_write = 1) and 0 for a read.
- R6: A transaction is 16 + 8·req_size serial clocks with cs_n held low throughout. The command goes first, MSB first. sclk idles low, mosi changes only while sclk is low, and the slave samples on the rising edge.
- R7: Write data byte k (req_wdata[8k+7:8k]) is the k-th data byte after the command, each byte MSB first.
- R8: On a read, the k-th data byte received on miso lands in rdata[8k+7:8k]. Bytes above the access size are zero, and rdata is valid in the cycle done is high.
- R9: A request with req_size not equal to 1, 2 or 4 raises err for exactly one cycle, the cycle after the request. It starts no transaction: cs_n stays high, sclk does not toggle, busy and done stay low.
- R10: A valid request seen while idle makes busy high from the next cycle until done. done is a one-cycle pulse in the same cycle that busy falls and cs_n rises.
- R11: Requests presented while busy is high are ignored: they do not change the transaction in progress, start nothing afterwards and raise no err.
- R12: Each sclk high and low phase lasts exactly HALF_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Register byte address |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for an illegal size |
| rdata | output | 32 | Read data, right-aligned, zero-extended |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The bench sweeps every address lane offset for all three sizes, in both directions and at several word addresses. A wrong lane mask, such as a 2-byte access keyed to bit 0 or a shifted 1-byte lane, shows up as a command word mismatch. A missing turnaround pad or a misplaced write flag does the same. The bench drives a distinct value into every miso byte, so reversed byte order or missing zero-extension shows up as wrong rdata, and a transaction one byte too long or too short shows up as a wrong clock count. It also offers every illegal size, and it raises requests in the middle of a transfer. A design that started on a bad size, or that latched a request while busy, would drop chip select or pulse done without cause.

// File: rtl/spi_be_pkg.sv
package spi_be_pkg;

    localparam int ADDR_W  = 11;
    localparam int CMD_W   = 16;
    localparam int TURN_W  = 2;
    localparam int BE_W    = 4;
    localparam int DATA_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int WADDR_W = ADDR_W - 2;
    localparam int RAW_W   = CMD_W - TURN_W;
    localparam int FRAME_W = CMD_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int POS_W   = $clog2(DATA_W);

    typedef struct packed {
        logic               write;
        logic [ADDR_W-1:0]  addr;
        logic [2:0]         nbytes;
        logic [DATA_W-1:0]  wdata;
    } acc_req_t;

    typedef enum logic {
        ST_IDLE,
        ST_XFER
    } ctl_state_e;

    function automatic logic size_legal(input logic [2:0] n);
        return (n == 3'd1) || (n == 3'd2) || (n == 3'd4);
    endfunction

    function automatic logic [BE_W-1:0] lane_mask(input logic [1:0] lo,
                                                  input logic [2:0] n);
        logic [BE_W-1:0] m;
        case (n)
            3'd1:    m = BE_W'(1) << lo;
            3'd2:    m = lo[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

    function automatic logic [CMD_W-1:0] build_cmd(input acc_req_t r);
        logic [RAW_W-1:0] raw;
        raw = '0;
        raw[BE_W +: WADDR_W] = r.addr[ADDR_W-1:2];
        raw[BE_W-1:0]        = lane_mask(r.addr[1:0], r.nbytes);
        raw[RAW_W-1]         = r.write;
        return {raw, TURN_W'(0)};
    endfunction

endpackage

// File: rtl/spi_be_cmdgen.sv
module spi_be_cmdgen
    import spi_be_pkg::*;
(
    input  acc_req_t            req_i,
    output logic [FRAME_W-1:0]  frame_o,
    output logic [CNT_W-1:0]    nbits_o,
    output logic                ok_o
);

    always_comb begin
        frame_o = '0;
        frame_o[FRAME_W-1 -: CMD_W] = build_cmd(req_i);
        if (req_i.write) begin
            for (int k = 0; k < BE_W; k++) begin
                frame_o[DATA_W-1-BYTE_W*k -: BYTE_W] = req_i.wdata[BYTE_W*k +: BYTE_W];
            end
        end
    end

    assign nbits_o = CNT_W'(CMD_W + BYTE_W * int'(req_i.nbytes));
    assign ok_o    = size_legal(req_i.nbytes);

endmodule

// File: rtl/spi_be_clkdiv.sv
module spi_be_clkdiv #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);

    generate
        if (HALF_DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int DIV_W = $clog2(HALF_DIV);
            localparam logic [DIV_W-1:0] LAST = DIV_W'(HALF_DIV - 1);
            logic [DIV_W-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || restart || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == LAST);
        end
    endgenerate

endmodule

// File: rtl/spi_be_shifter.sv
module spi_be_shifter
    import spi_be_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   nbits,
    input  logic               tick,
    input  logic               miso,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    output logic               fin,
    output logic [DATA_W-1:0]  rx_data
);

    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   idx_q;
    logic [CNT_W-1:0]   last_q;
    logic [POS_W-1:0]   rel;
    logic [POS_W-1:0]   rx_pos;
    logic               in_data;

    assign rel     = POS_W'(idx_q - CNT_W'(CMD_W));
    assign rx_pos  = {rel[POS_W-1:3], ~rel[2:0]};
    assign in_data = (idx_q >= CNT_W'(CMD_W));
    assign mosi    = sh_q[FRAME_W-1];
    assign fin     = !cs_n && tick && sclk && (idx_q == last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n    <= 1'b1;
            sclk    <= 1'b0;
            sh_q    <= '0;
            idx_q   <= '0;
            last_q  <= '0;
            rx_data <= '0;
        end else if (start) begin
            cs_n    <= 1'b0;
            sclk    <= 1'b0;
            sh_q    <= frame;
            idx_q   <= '0;
            last_q  <= nbits - 1'b1;
            rx_data <= '0;
        end else if (!cs_n && tick) begin
            if (!sclk) begin
                sclk <= 1'b1;
                if (in_data) begin
                    rx_data[rx_pos] <= miso;
                end
            end else begin
                sclk <= 1'b0;
                if (idx_q == last_q) begin
                    cs_n <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                    sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/spi_be_regmaster.sv
module spi_be_regmaster
    import spi_be_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [10:0]       req_addr,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [31:0]       rdata,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);

    acc_req_t            req;
    logic [FRAME_W-1:0]  frame;
    logic [CNT_W-1:0]    nbits;
    logic                size_ok;
    ctl_state_e          state_q;
    logic                wr_q;
    logic                idle;
    logic                start;
    logic                tick;
    logic                fin;
    logic [DATA_W-1:0]   rx_data;

    assign req.write  = req_write;
    assign req.addr   = req_addr;
    assign req.nbytes = req_size;
    assign req.wdata  = req_wdata;

    assign idle  = (state_q == ST_IDLE);
    assign start = idle && req_valid && size_ok;
    assign busy  = !idle;

    spi_be_cmdgen u_cmdgen (
        .req_i   (req),
        .frame_o (frame),
        .nbits_o (nbits),
        .ok_o    (size_ok)
    );

    spi_be_clkdiv #(.HALF_DIV(HALF_DIV)) u_clkdiv (
        .clk     (clk),
        .rst     (rst),
        .run     (!cs_n),
        .restart (start),
        .tick    (tick)
    );

    spi_be_shifter u_shifter (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .frame   (frame),
        .nbits   (nbits),
        .tick    (tick),
        .miso    (miso),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .mosi    (mosi),
        .fin     (fin),
        .rx_data (rx_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= fin;
            err  <= idle && req_valid && !size_ok;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_XFER;
                        wr_q    <= req_write;
                    end
                end
                ST_XFER: begin
                    if (fin) begin
                        state_q <= ST_IDLE;
                        if (!wr_q) begin
                            rdata <= rx_data;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_be_regmaster_chk.sv
module spi_be_regmaster_chk #(
    parameter int HALF_DIV = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [2:0] req_size,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       sclk,
    input logic       cs_n,
    input logic       mosi
);

    logic        legal;
    logic        sclk_q;
    int unsigned hold;

    assign legal = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            hold   <= 0;
        end else begin
            sclk_q <= sclk;
            if (cs_n)               hold <= 0;
            else if (sclk != sclk_q) hold <= 1;
            else                    hold <= hold + 1;
        end
    end

    // R6: serial clock rests low while deselected
    a_r6_sclk_idle: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R6: mosi only moves while sclk is low
    a_r6_mosi_stable: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n) && sclk) |-> $stable(mosi));

    // R9: illegal size while idle gives err and no start
    a_r9_bad_size: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && !legal) |=> (err && cs_n && !busy));

    // R9: err never coincides with an active transfer
    a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
        err |-> (cs_n && !done));

    // R10: legal request while idle starts a transfer next cycle
    a_r10_accept: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && legal) |=> (busy && !cs_n));

    // R10: done is a single-cycle pulse that ends the transfer
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && cs_n) ##1 !done);

    // R10: chip select low only while busy
    a_r10_cs_busy: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

    // R12: every sclk phase lasts HALF_DIV clocks
    a_r12_half_period: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && (sclk != sclk_q)) |-> (hold == HALF_DIV));

endmodule

bind spi_be_regmaster spi_be_regmaster_chk #(.HALF_DIV(HALF_DIV)) u_chk (.*);

// File: tb/spi_be_regmaster_test.sv
`timescale 1ns/1ps
module spi_be_regmaster_test;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [10:0] req_addr = '0;
    logic [2:0]  req_size = 3'd1;
    logic [31:0] req_wdata = '0;
    logic        busy, done, err, sclk, cs_n, mosi;
    logic [31:0] rdata;
    logic        miso = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    // device model state
    logic [47:0] cap = '0;
    int          nb = 0;
    int          sclk_rises = 0;
    int          hi_cycles = 0;
    int          done_total = 0;
    logic [31:0] resp_word = '0;

    always #5 clk = ~clk;

    spi_be_regmaster #(.HALF_DIV(HALF)) uut (
        .clk, .rst, .req_valid, .req_write, .req_addr, .req_size, .req_wdata,
        .busy, .done, .err, .rdata, .sclk, .cs_n, .mosi, .miso
    );

    function automatic logic resp_bit(input int idx);
        int d;
        if (idx < 16) return 1'b1;
        d = idx - 16;
        if (d >= 32) return 1'b1;
        return resp_word[(d / 8) * 8 + 7 - (d % 8)];
    endfunction

    always @(negedge cs_n) begin
        nb   = 0;
        miso = resp_bit(0);
    end

    always @(posedge sclk) begin
        sclk_rises++;
        if (!cs_n) begin
            cap = {cap[46:0], mosi};
            nb++;
        end
    end

    always @(negedge sclk) if (!cs_n) miso = resp_bit(nb);

    always @(posedge clk) begin
        if (sclk) hi_cycles++;
        if (done) done_total++;
    end

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_cmd(input bit wr, input logic [10:0] a,
                                            input int n);
        int m;
        int aa;
        aa = int'(a);
        if (n == 1)      m = 1 << (aa % 4);
        else if (n == 2) m = ((aa / 2) % 2 == 1) ? 12 : 3;
        else             m = 15;
        return 16'((((aa / 4) * 16 + m) * 4) + (wr ? 32768 : 0));
    endfunction

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic run_txn(input bit wr, input logic [10:0] a, input int n,
                           input logic [31:0] wd, input logic [31:0] rv);
        int          hi0;
        int          d0;
        logic [15:0] ec;
        logic [15:0] gc;
        logic [31:0] mask;
        resp_word = rv;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_size  = 3'(n);
        req_wdata = wd;
        hi0 = hi_cycles;
        d0  = done_total;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1 && cs_n == 1'b0, "R10 busy/cs after accept", {busy, cs_n}, 2'b10);
        wait_done();
        check(done == 1'b1 && busy == 1'b0 && cs_n == 1'b1, "R10 done ends transfer",
              {done, busy, cs_n}, 3'b101);
        ec = exp_cmd(wr, a, n);
        gc = 16'(cap >> (8 * n));
        check(gc[14:6] == ec[14:6] && gc[1:0] == 2'b00, "R1 word address and pad", gc, ec);
        if (n == 1)      check(gc[5:2] == ec[5:2], "R2 single-byte lane", gc, ec);
        else if (n == 2) check(gc[5:2] == ec[5:2], "R3 two-byte lanes", gc, ec);
        else             check(gc[5:2] == ec[5:2], "R4 four-byte lanes", gc, ec);
        check(gc[15] == wr, "R5 write flag", gc, ec);
        check(nb == 16 + 8 * n, "R6 serial clock count", nb, 16 + 8 * n);
        check(hi_cycles - hi0 == HALF * (16 + 8 * n), "R12 sclk high time",
              hi_cycles - hi0, HALF * (16 + 8 * n));
        if (wr) begin
            for (int k = 0; k < n; k++) begin
                check(8'(cap >> (8 * (n - 1 - k))) == wd[8 * k +: 8], "R7 write byte order",
                      8'(cap >> (8 * (n - 1 - k))), wd[8 * k +: 8]);
            end
        end else begin
            mask = (n == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * n)) - 1);
            check(rdata == (rv & mask), "R8 read data aligned", rdata, rv & mask);
        end
        @(negedge clk);
        check(done == 1'b0 && done_total - d0 == 1, "R10 single done pulse", done, 0);
    endtask

    task automatic bad_size(input logic [2:0] s);
        int r0;
        int d0;
        r0 = sclk_rises;
        d0 = done_total;
        @(negedge clk);
        req_valid = 1'b1;
        req_size  = s;
        req_addr  = 11'h155;
        @(negedge clk);
        req_valid = 1'b0;
        check(err == 1'b1 && busy == 1'b0 && cs_n == 1'b1, "R9 err on illegal size",
              {err, busy, cs_n}, 3'b101);
        @(negedge clk);
        check(err == 1'b0, "R9 err single cycle", err, 0);
        repeat (8) @(negedge clk);
        check(sclk_rises == r0 && done_total == d0 && cs_n == 1'b1, "R9 no transfer started",
              sclk_rises - r0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0 && err == 1'b0,
              "R10 reset state", {cs_n, sclk, busy, done, err}, 5'b10000);
        check(rdata == 32'h0, "R8 reset rdata", rdata, 0);

        for (int wr = 0; wr < 2; wr++) begin
            for (int si = 0; si < 3; si++) begin
                for (int hi = 0; hi < 3; hi++) begin
                    for (int lo = 0; lo < 4; lo++) begin
                        int          n;
                        int          w;
                        logic [10:0] a;
                        logic [31:0] wd;
                        logic [31:0] rv;
                        n  = (si == 0) ? 1 : (si == 1) ? 2 : 4;
                        w  = (hi == 0) ? 0 : (hi == 1) ? 9'h1FF : 9'h0A5;
                        a  = 11'(w * 4 + lo);
                        wd = 32'hA1B2C3D4 ^ (32'(a) * 32'h01010101);
                        rv = 32'h5E6F7A8B + 32'(a) * 32'h00010203 + 32'(n);
                        run_txn(wr[0], a, n, wd, rv);
                    end
                end
            end
        end

        bad_size(3'd0);
        bad_size(3'd3);
        bad_size(3'd5);
        bad_size(3'd6);
        bad_size(3'd7);

        // R11: requests during a transfer are dropped
        begin
            int d0;
            logic [15:0] gc;
            logic [15:0] ec;
            d0 = done_total;
            @(negedge clk);
            req_valid = 1'b1;
            req_write = 1'b1;
            req_addr  = 11'h2C4;
            req_size  = 3'd4;
            req_wdata = 32'h0BAD_F00D;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (20) @(negedge clk);
            req_valid = 1'b1;
            req_write = 1'b0;
            req_addr  = 11'h013;
            req_size  = 3'd2;
            @(negedge clk);
            req_size  = 3'd3;
            @(negedge clk);
            req_valid = 1'b0;
            check(err == 1'b0, "R11 no err while busy", err, 0);
            wait_done();
            ec = exp_cmd(1'b1, 11'h2C4, 4);
            gc = 16'(cap >> 32);
            check(gc == ec, "R11 transfer unchanged", gc, ec);
            repeat (10) @(negedge clk);
            check(busy == 1'b0 && cs_n == 1'b1 && done_total - d0 == 1,
                  "R11 nothing started later", done_total - d0, 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule